// File: doc/BRIEF.md
# Trace Line Lookup and Next-Fetch Selection

This block sits beside the conventional instruction cache in a wide fetch front end. It holds a small direct-mapped set of trace lines. A trace line records a run of instructions in the order they executed, including instructions that follow taken branches. Each cycle the fetch unit can present a fetch address together with the branch predictor's directions for up to `MAX_BR` branches. One cycle later the block reports three things: whether the stored line at that index can supply the fetch, how many instructions to deliver, and where fetch goes next. On a miss the fetch address comes back unchanged, and the fetch unit falls back to the instruction cache.

A line is usable only when all of these hold: it is valid, its tag equals the upper fetch address bits, and the path recorded in it agrees with the current predictions. Only the first (branch count − 1) predicted directions take part in the path check. If the trace ends in a branch, the prediction for that final branch chooses between the stored target and fall-through addresses. A fill port writes a complete line into the slot addressed by the line's start address.

Top module: `tc_fetch_lookup`

## Requirements
- R1: After reset no response is flagged (`rsp_valid`=0) and every line is invalid, so any lookup misses. A reset in mid-run also discards previously filled lines.
- R2: A lookup presented with `lk_req`=1 is answered exactly one clock later with `rsp_valid`=1. A cycle without a request gives `rsp_valid`=0 one clock later.
- R3: A hit requires a valid line and a tag match. With the defaults the index is `lk_pc[5:2]` and the tag is `lk_pc[31:6]`, so two addresses that differ only in bits 31:6 share one slot but do not both hit.
- R4: Bit i of `lk_pred` and of the stored flags stands for the i-th branch of the trace, with 1 meaning taken. A hit requires `lk_pred[i]` to equal flag bit i for every i < (branch count − 1). Higher prediction bits have no effect on the hit.
- R5: `inst_cnt` equals the stored line length on a hit and is 0 otherwise.
- R6: On a hit of a line that ends in a branch, `next_pc` is the stored target when `lk_pred[branch count − 1]` is 1, and the stored fall-through address when that bit is 0.
- R7: On a hit of a line that does not end in a branch, `next_pc` is the stored fall-through address, whatever the predictions are. This includes a line that holds no branch.
- R8: On a miss, `hit`=0 and `next_pc` equals the looked-up fetch address.
- R9: If a fill and a lookup reach the same slot in the same cycle, the lookup answers from the line as it was before the fill. The filled line answers from the next lookup on.
- R10: A fill replaces whatever line occupied its slot. The previous trace at that index then misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| lk_req | input | 1 | Lookup request this cycle |
| lk_pc | input | ADDR_W | Fetch address to look up |
| lk_pred | input | MAX_BR | Predicted directions, bit i = branch i, 1 = taken |
| fill_en | input | 1 | Write a trace line this cycle |
| fill_pc | input | ADDR_W | Start address of the trace being written |
| fill_flags | input | FLG_W | Recorded directions of all but the last branch |
| fill_nbr | input | NBR_W | Number of branches in the trace |
| fill_ends_br | input | 1 | Trace ends in a branch (requires fill_nbr ≥ 1) |
| fill_len | input | LEN_W | Instruction count of the trace |
| fill_fall | input | ADDR_W | Fall-through address at the trace end |
| fill_tgt | input | ADDR_W | Taken-target address at the trace end |
| rsp_valid | output | 1 | Response for the previous cycle's lookup |
| hit | output | 1 | Trace line supplies this fetch |
| inst_cnt | output | LEN_W | Instructions to deliver (0 on miss) |
| next_pc | output | ADDR_W | Next fetch address |

## Verification
The lookup read and the fill write can land on the same slot in the same clock. This is the one place where two functions of the block meet. The bench provokes it by driving a lookup and a fill that address an already-occupied slot on the same falling edge. The response in the following cycle must still show the old line's length and next address. A second lookup then has to return the new line's values. Eviction and mid-run reset are judged the same way, by looking up both the old and the new start addresses through the normal lookup port.

// File: rtl/tc_pkg.sv
package tc_pkg;

   // Source of the next fetch address chosen by the selection logic
   typedef enum logic [1:0] {
      NPC_HOLD = 2'd0,  // miss: refetch the same address from the icache
      NPC_FALL = 2'd1,  // trace end falls through
      NPC_TGT  = 2'd2   // trace end branch predicted taken
   } npc_src_e;

   // Width helper: at least one bit even when a count is zero
   function automatic int unsigned min1(input int unsigned w);
      return (w < 1) ? 1 : w;
   endfunction

endpackage

// File: rtl/tc_line_store.sv
module tc_line_store #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned IDX_W  = 4,
   parameter int unsigned TAG_W  = 26,
   parameter int unsigned FLG_W  = 2,
   parameter int unsigned NBR_W  = 2,
   parameter int unsigned LEN_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   // write side
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [TAG_W-1:0]  wr_tag,
   input  logic [FLG_W-1:0]  wr_flags,
   input  logic [NBR_W-1:0]  wr_nbr,
   input  logic              wr_ends,
   input  logic [LEN_W-1:0]  wr_len,
   input  logic [ADDR_W-1:0] wr_fall,
   input  logic [ADDR_W-1:0] wr_tgt,
   // registered read side
   input  logic              rd_en,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic              q_valid,
   output logic [TAG_W-1:0]  q_tag,
   output logic [FLG_W-1:0]  q_flags,
   output logic [NBR_W-1:0]  q_nbr,
   output logic              q_ends,
   output logic [LEN_W-1:0]  q_len,
   output logic [ADDR_W-1:0] q_fall,
   output logic [ADDR_W-1:0] q_tgt
);

   localparam int unsigned LINES = 1 << IDX_W;

   logic [LINES-1:0]  vld_q;
   logic [TAG_W-1:0]  tag_q  [LINES];
   logic [FLG_W-1:0]  flg_q  [LINES];
   logic [NBR_W-1:0]  nbr_q  [LINES];
   logic              ends_q [LINES];
   logic [LEN_W-1:0]  len_q  [LINES];
   logic [ADDR_W-1:0] fall_q [LINES];
   logic [ADDR_W-1:0] tgt_q  [LINES];

   // valid bits carry reset; payload arrays are qualified by them
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= '0;
      end else if (wr_en) begin
         vld_q[wr_idx] <= 1'b1;
      end
   end

   genvar g;
   generate
      for (g = 0; g < LINES; g++) begin : g_line
         always_ff @(posedge clk) begin
            if (wr_en && (wr_idx == IDX_W'(g))) begin
               tag_q[g]  <= wr_tag;
               flg_q[g]  <= wr_flags;
               nbr_q[g]  <= wr_nbr;
               ends_q[g] <= wr_ends;
               len_q[g]  <= wr_len;
               fall_q[g] <= wr_fall;
               tgt_q[g]  <= wr_tgt;
            end
         end
      end
   endgenerate

   // Read register: samples contents before this edge's write (old data wins)
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_valid <= 1'b0;
      end else if (rd_en) begin
         q_valid <= vld_q[rd_idx];
      end
   end

   always_ff @(posedge clk) begin
      if (rd_en) begin
         q_tag   <= tag_q[rd_idx];
         q_flags <= flg_q[rd_idx];
         q_nbr   <= nbr_q[rd_idx];
         q_ends  <= ends_q[rd_idx];
         q_len   <= len_q[rd_idx];
         q_fall  <= fall_q[rd_idx];
         q_tgt   <= tgt_q[rd_idx];
      end
   end

endmodule

// File: rtl/tc_path_match.sv
module tc_path_match #(
   parameter int unsigned MAX_BR = 3,
   parameter int unsigned FLG_W  = 2,
   parameter int unsigned NBR_W  = 2
) (
   input  logic [FLG_W-1:0]  flags,
   input  logic [NBR_W-1:0]  nbr,
   input  logic [MAX_BR-1:0] pred,
   output logic              path_ok
);

   generate
      if (MAX_BR == 1) begin : g_single
         // the only branch is the last one: nothing to compare
         assign path_ok = 1'b1;
      end else begin : g_multi
         logic [MAX_BR-2:0] bit_ok;
         genvar i;
         for (i = 0; i < MAX_BR - 1; i++) begin : g_cmp
            logic inside_path;
            // branch i is internal when i < nbr-1, i.e. i+1 < nbr
            assign inside_path = (NBR_W'(i + 1) < nbr);
            assign bit_ok[i]   = !inside_path || (pred[i] == flags[i]);
         end
         assign path_ok = &bit_ok;
      end
   endgenerate

endmodule

// File: rtl/tc_next_pc.sv
module tc_next_pc
   import tc_pkg::*;
#(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned MAX_BR = 3,
   parameter int unsigned NBR_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hit,
   input  logic              ends_br,
   input  logic [NBR_W-1:0]  nbr,
   input  logic [MAX_BR-1:0] pred,
   input  logic [ADDR_W-1:0] req_pc,
   input  logic [ADDR_W-1:0] fall,
   input  logic [ADDR_W-1:0] tgt,
   output logic [ADDR_W-1:0] next_pc
);

   logic     last_taken;
   npc_src_e src;

   // prediction for the final branch sits at position nbr-1
   always_comb begin
      last_taken = 1'b0;
      for (int i = 0; i < MAX_BR; i++) begin
         if (nbr == NBR_W'(i + 1)) last_taken = pred[i];
      end
   end

   always_comb begin
      if (!hit)                                      src = NPC_HOLD;
      else if (ends_br && (nbr != '0) && last_taken) src = NPC_TGT;
      else                                           src = NPC_FALL;
   end

   always_comb begin
      unique case (src)
         NPC_TGT:  next_pc = tgt;
         NPC_FALL: next_pc = fall;
         default:  next_pc = req_pc;
      endcase
   end

   // R7: a trace without a closing branch always continues sequentially
   p_plain_end_falls_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && !ends_br) |-> (next_pc == fall));

   // R6: target is only chosen for a trace closing in a branch
   p_tgt_needs_branch_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && (next_pc != fall) && (tgt != fall)) |-> (ends_br && next_pc == tgt));

endmodule

// File: rtl/tc_fetch_lookup.sv
module tc_fetch_lookup
   import tc_pkg::*;
#(
   parameter int unsigned ADDR_W  = 32,
   parameter int unsigned IDX_W   = 4,
   parameter int unsigned ALIGN_W = 2,
   parameter int unsigned MAX_BR  = 3,
   parameter int unsigned MAX_LEN = 16,
   localparam int unsigned TAG_W  = ADDR_W - IDX_W - ALIGN_W,
   localparam int unsigned FLG_W  = min1(MAX_BR - 1),
   localparam int unsigned NBR_W  = $clog2(MAX_BR + 1),
   localparam int unsigned LEN_W  = $clog2(MAX_LEN + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lk_req,
   input  logic [ADDR_W-1:0] lk_pc,
   input  logic [MAX_BR-1:0] lk_pred,
   input  logic              fill_en,
   input  logic [ADDR_W-1:0] fill_pc,
   input  logic [FLG_W-1:0]  fill_flags,
   input  logic [NBR_W-1:0]  fill_nbr,
   input  logic              fill_ends_br,
   input  logic [LEN_W-1:0]  fill_len,
   input  logic [ADDR_W-1:0] fill_fall,
   input  logic [ADDR_W-1:0] fill_tgt,
   output logic              rsp_valid,
   output logic              hit,
   output logic [LEN_W-1:0]  inst_cnt,
   output logic [ADDR_W-1:0] next_pc
);

   // elaboration-time parameter checks
   generate
      if (MAX_BR < 1) begin : g_bad_br
         $error("tc_fetch_lookup: MAX_BR must be at least 1");
      end
      if (IDX_W < 1 || IDX_W > 10) begin : g_bad_idx
         $error("tc_fetch_lookup: IDX_W must be 1..10");
      end
      if (ADDR_W <= IDX_W + ALIGN_W) begin : g_bad_addr
         $error("tc_fetch_lookup: ADDR_W too small for index and alignment");
      end
      if (MAX_LEN < 1) begin : g_bad_len
         $error("tc_fetch_lookup: MAX_LEN must be at least 1");
      end
   endgenerate

   logic [IDX_W-1:0] lk_idx, wr_idx;
   logic [TAG_W-1:0] wr_tag;
   assign lk_idx = lk_pc[ALIGN_W +: IDX_W];
   assign wr_idx = fill_pc[ALIGN_W +: IDX_W];
   assign wr_tag = fill_pc[ADDR_W-1 -: TAG_W];

   // captured request for the response cycle
   logic              req_q;
   logic [ADDR_W-1:0] pc_q;
   logic [MAX_BR-1:0] pred_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) req_q <= 1'b0;
      else        req_q <= lk_req;
   end

   always_ff @(posedge clk) begin
      if (lk_req) begin
         pc_q   <= lk_pc;
         pred_q <= lk_pred;
      end
   end

   logic              l_valid, l_ends;
   logic [TAG_W-1:0]  l_tag;
   logic [FLG_W-1:0]  l_flags;
   logic [NBR_W-1:0]  l_nbr;
   logic [LEN_W-1:0]  l_len;
   logic [ADDR_W-1:0] l_fall, l_tgt;

   tc_line_store #(
      .ADDR_W(ADDR_W), .IDX_W(IDX_W), .TAG_W(TAG_W),
      .FLG_W(FLG_W), .NBR_W(NBR_W), .LEN_W(LEN_W)
   ) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (fill_en),
      .wr_idx   (wr_idx),
      .wr_tag   (wr_tag),
      .wr_flags (fill_flags),
      .wr_nbr   (fill_nbr),
      .wr_ends  (fill_ends_br),
      .wr_len   (fill_len),
      .wr_fall  (fill_fall),
      .wr_tgt   (fill_tgt),
      .rd_en    (lk_req),
      .rd_idx   (lk_idx),
      .q_valid  (l_valid),
      .q_tag    (l_tag),
      .q_flags  (l_flags),
      .q_nbr    (l_nbr),
      .q_ends   (l_ends),
      .q_len    (l_len),
      .q_fall   (l_fall),
      .q_tgt    (l_tgt)
   );

   logic path_ok, tag_ok;

   tc_path_match #(
      .MAX_BR(MAX_BR), .FLG_W(FLG_W), .NBR_W(NBR_W)
   ) u_path (
      .flags   (l_flags),
      .nbr     (l_nbr),
      .pred    (pred_q),
      .path_ok (path_ok)
   );

   assign tag_ok    = (l_tag == pc_q[ADDR_W-1 -: TAG_W]);
   assign rsp_valid = req_q;
   assign hit       = req_q && l_valid && tag_ok && path_ok;
   assign inst_cnt  = hit ? l_len : '0;

   tc_next_pc #(
      .ADDR_W(ADDR_W), .MAX_BR(MAX_BR), .NBR_W(NBR_W)
   ) u_npc (
      .clk     (clk),
      .rst_n   (rst_n),
      .hit     (hit),
      .ends_br (l_ends),
      .nbr     (l_nbr),
      .pred    (pred_q),
      .req_pc  (pc_q),
      .fall    (l_fall),
      .tgt     (l_tgt),
      .next_pc (next_pc)
   );

   // R2: one response per request, exactly one cycle later
   p_rsp_after_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
      lk_req |=> rsp_valid);
   p_no_rsp_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_req |=> !rsp_valid);

   // R8: a miss hands back the address that was looked up
   p_miss_holds_pc_r8: assert property (@(posedge clk) disable iff (!rst_n)
      lk_req |=> (hit || next_pc == $past(lk_pc)));

   // R5: nothing is delivered without a hit
   p_miss_no_insts_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !hit |-> (inst_cnt == '0));

   // R3: a hit is only ever reported in a response cycle
   p_hit_in_rsp_r3: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> rsp_valid);

   // R6: a line that closes in a branch must count that branch
   p_fill_shape_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_en && fill_ends_br) |-> (fill_nbr != '0));
   p_fill_nbr_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
      fill_en |-> (fill_nbr <= NBR_W'(MAX_BR)));

endmodule

// File: tb/tb_tc_fetch_lookup.sv
module tb_tc_fetch_lookup;

   localparam int CLK_PERIOD = 10;
   localparam int AW = 32;
   localparam int MB = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          lk_req = 1'b0;
   logic [AW-1:0] lk_pc = '0;
   logic [MB-1:0] lk_pred = '0;
   logic          fill_en = 1'b0;
   logic [AW-1:0] fill_pc = '0;
   logic [1:0]    fill_flags = '0;
   logic [1:0]    fill_nbr = '0;
   logic          fill_ends_br = 1'b0;
   logic [4:0]    fill_len = '0;
   logic [AW-1:0] fill_fall = '0;
   logic [AW-1:0] fill_tgt = '0;
   logic          rsp_valid, hit;
   logic [4:0]    inst_cnt;
   logic [AW-1:0] next_pc;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   tc_fetch_lookup dut (
      .clk(clk), .rst_n(rst_n),
      .lk_req(lk_req), .lk_pc(lk_pc), .lk_pred(lk_pred),
      .fill_en(fill_en), .fill_pc(fill_pc), .fill_flags(fill_flags),
      .fill_nbr(fill_nbr), .fill_ends_br(fill_ends_br), .fill_len(fill_len),
      .fill_fall(fill_fall), .fill_tgt(fill_tgt),
      .rsp_valid(rsp_valid), .hit(hit), .inst_cnt(inst_cnt), .next_pc(next_pc)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input logic [AW-1:0] act, input logic [AW-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // stage a fill on the falling edge; caller clocks it
   task automatic set_fill(input logic [AW-1:0] pc, input logic [1:0] flg,
                           input logic [1:0] nbr, input logic ends,
                           input logic [4:0] len, input logic [AW-1:0] fall,
                           input logic [AW-1:0] tgt);
      fill_en = 1'b1; fill_pc = pc; fill_flags = flg; fill_nbr = nbr;
      fill_ends_br = ends; fill_len = len; fill_fall = fall; fill_tgt = tgt;
   endtask

   task automatic do_fill(input logic [AW-1:0] pc, input logic [1:0] flg,
                          input logic [1:0] nbr, input logic ends,
                          input logic [4:0] len, input logic [AW-1:0] fall,
                          input logic [AW-1:0] tgt);
      @(negedge clk);
      set_fill(pc, flg, nbr, ends, len, fall, tgt);
      @(negedge clk);
      fill_en = 1'b0;
   endtask

   // request on a falling edge; response sampled on the next falling edge
   task automatic look(input logic [AW-1:0] pc, input logic [MB-1:0] pred,
                       input string req, input bit exp_hit,
                       input logic [4:0] exp_cnt, input logic [AW-1:0] exp_npc);
      @(negedge clk);
      lk_req = 1'b1; lk_pc = pc; lk_pred = pred;
      @(negedge clk);
      lk_req = 1'b0;
      check(rsp_valid == 1'b1, "R2", "rsp_valid", AW'(rsp_valid), 1);
      check(hit == exp_hit, req, "hit", AW'(hit), AW'(exp_hit));
      check(inst_cnt == exp_cnt, req, "inst_cnt", AW'(inst_cnt), AW'(exp_cnt));
      check(next_pc == exp_npc, req, "next_pc", next_pc, exp_npc);
   endtask

   task automatic t_reset_state();
      check(rsp_valid == 1'b0, "R1", "rsp_valid after reset", AW'(rsp_valid), 0);
      look(32'h0000_0100, 3'b000, "R1", 1'b0, 5'd0, 32'h0000_0100);
      look(32'h0000_1000, 3'b111, "R8", 1'b0, 5'd0, 32'h0000_1000);
      @(negedge clk);
      check(rsp_valid == 1'b0, "R2", "idle rsp_valid", AW'(rsp_valid), 0);
   endtask

   task automatic t_three_branch();
      // flags: br0 taken, br1 not taken; ends in branch 2
      do_fill(32'h0000_1000, 2'b01, 2'd3, 1'b1, 5'd12, 32'h0000_2000, 32'h0000_3000);
      look(32'h0000_1000, 3'b101, "R6", 1'b1, 5'd12, 32'h0000_3000);
      look(32'h0000_1000, 3'b001, "R6", 1'b1, 5'd12, 32'h0000_2000);
      look(32'h0000_1000, 3'b011, "R4", 1'b0, 5'd0, 32'h0000_1000);
      look(32'h0000_1000, 3'b100, "R4", 1'b0, 5'd0, 32'h0000_1000);
      look(32'h0000_1040, 3'b101, "R3", 1'b0, 5'd0, 32'h0000_1040);
   endtask

   task automatic t_single_branch();
      // one branch which closes the trace: stored flags must be ignored
      do_fill(32'h0000_2004, 2'b11, 2'd1, 1'b1, 5'd7, 32'h0000_5000, 32'h0000_6000);
      look(32'h0000_2004, 3'b110, "R4", 1'b1, 5'd7, 32'h0000_5000);
      look(32'h0000_2004, 3'b001, "R6", 1'b1, 5'd7, 32'h0000_6000);
   endtask

   task automatic t_plain_end();
      // two branches, not ending in a branch: only br0 compared
      do_fill(32'h0000_2008, 2'b10, 2'd2, 1'b0, 5'd9, 32'h0000_7000, 32'h0000_8000);
      look(32'h0000_2008, 3'b110, "R7", 1'b1, 5'd9, 32'h0000_7000);
      look(32'h0000_2008, 3'b111, "R4", 1'b0, 5'd0, 32'h0000_2008);
      // no branches at all
      do_fill(32'h0000_200C, 2'b00, 2'd0, 1'b0, 5'd16, 32'h0000_9000, 32'h0000_A000);
      look(32'h0000_200C, 3'b111, "R7", 1'b1, 5'd16, 32'h0000_9000);
      look(32'h0000_200C, 3'b000, "R5", 1'b1, 5'd16, 32'h0000_9000);
   endtask

   task automatic t_same_cycle();
      @(negedge clk);
      set_fill(32'h0000_1000, 2'b00, 2'd0, 1'b0, 5'd5, 32'h0000_4444, 32'h0000_0000);
      lk_req = 1'b1; lk_pc = 32'h0000_1000; lk_pred = 3'b101;
      @(negedge clk);
      fill_en = 1'b0; lk_req = 1'b0;
      check(hit == 1'b1, "R9", "hit old line", AW'(hit), 1);
      check(inst_cnt == 5'd12, "R9", "old inst_cnt", AW'(inst_cnt), 12);
      check(next_pc == 32'h0000_3000, "R9", "old next_pc", next_pc, 32'h0000_3000);
      look(32'h0000_1000, 3'b101, "R9", 1'b1, 5'd5, 32'h0000_4444);
   endtask

   task automatic t_evict();
      do_fill(32'h0000_1040, 2'b00, 2'd0, 1'b0, 5'd3, 32'h0000_1100, 32'h0000_0000);
      look(32'h0000_1000, 3'b000, "R10", 1'b0, 5'd0, 32'h0000_1000);
      look(32'h0000_1040, 3'b000, "R10", 1'b1, 5'd3, 32'h0000_1100);
   endtask

   task automatic t_midrun_reset();
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      check(rsp_valid == 1'b0, "R1", "rsp_valid after reset", AW'(rsp_valid), 0);
      look(32'h0000_1040, 3'b000, "R1", 1'b0, 5'd0, 32'h0000_1040);
      look(32'h0000_2004, 3'b001, "R1", 1'b0, 5'd0, 32'h0000_2004);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset_state();
      t_three_branch();
      t_single_branch();
      t_plain_end();
      t_same_cycle();
      t_evict();
      t_midrun_reset();
      repeat (2) @(negedge clk);
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule